// File: doc/BRIEF.md
# Three-Phase Gate-Drive Interlock

This block sits between a PWM generator and the gate drivers of a three-phase bridge. It takes a high-side and a low-side command for each phase and produces one gate-enable bit per switch. Every command bit first passes through its own deglitch filter. A filter only accepts a new level once the raw input has held that level for a set number of clocks. After the filters, each phase resolves its two commands so that its two switches are never enabled together. A global enable input and a fault-shutdown input from a separate overcurrent detector then gate all six switches.

The enable input has its own filter, and that filter is shorter than the filter on the PWM commands. The fault input is not filtered, because the protection block has already qualified it. It removes drive on the first clock edge at which it is seen. All six PWM channels have exactly the same latency, so the dead time set upstream in the PWM generator is kept. Every output is registered and resets to off.

Top module: `gdi_interlock`

## Requirements
- R1: With the filtered high command at 1 and the filtered low command at 0, a phase drives `ho`=1 and `lo`=0 while enable is on and fault is off.
- R2: With the filtered high command at 0 and the filtered low command at 1, a phase drives `ho`=0 and `lo`=1 while enable is on and fault is off.
- R3: With both filtered commands of a phase at 0, that phase drives `ho`=0 and `lo`=0.
- R4: With both filtered commands of a phase at 1, that phase drives `ho`=0 and `lo`=0. A phase never has `ho` and `lo` at 1 together.
- R5: While the filtered enable is 0, all six outputs are 0, whatever the PWM commands are.
- R6: While `fault_in` is 1, all six outputs are 0, whatever the other inputs are.
- R7: A pulse on any `hin` or `lin` bit that lasts fewer than FILT_IN consecutive clocks leaves the outputs unchanged.
- R8: A pulse on `en_in` that lasts fewer than FILT_EN clocks has no effect. A held change of `en_in` reaches the outputs FILT_EN+1 rising edges after the first edge that samples it.
- R9: A held change on any of the six PWM inputs reaches its output exactly FILT_IN+1 rising edges after the first edge that samples it. This latency is the same for every channel.
- R10: When `fault_in` rises, all outputs are 0 after the next rising edge.
- R11: While `rst` is high, and on the first edge after it is released, all outputs are 0. Every filter resets to a filtered value of 0, so enable must be held for FILT_EN clocks before any output turns on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hin | input | NPH | High-side PWM commands, one bit per phase |
| lin | input | NPH | Low-side PWM commands, one bit per phase |
| en_in | input | 1 | Global drive enable, active high |
| fault_in | input | 1 | Overcurrent shutdown request, active high |
| ho | output | NPH | High-side gate enables, registered |
| lo | output | NPH | Low-side gate enables, registered |

## Verification
Two things can land on the same clock edge and both act on a phase: a PWM transition that has just cleared its filter, and a shutdown, either from the fault input or from an enable change that has just cleared the shorter enable filter. The random phase of the bench holds PWM patterns for random lengths around the filter length. It also toggles enable and fault on their own, so filter expiries and shutdowns often share an edge. A behavioural model keeps a history queue of every input and is compared with all six outputs on every clock. Shutdown must always win, and the PWM state must come back with the correct latency once the gating is released.

// File: rtl/gdi_pkg.sv
package gdi_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10
  } leg_state_e;

  function automatic leg_state_e resolve_leg(input logic hi_cmd, input logic lo_cmd);
    case ({hi_cmd, lo_cmd})
      2'b10:   return LEG_HIGH;
      2'b01:   return LEG_LOW;
      default: return LEG_OFF;
    endcase
  endfunction

endpackage

// File: rtl/gdi_deglitch.sv
module gdi_deglitch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean   <= 1'b0;
      run_cnt <= '0;
    end else if (raw == clean) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      clean   <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r7_follows_raw: assert property (@(posedge clk) disable iff (rst)
    (clean != $past(clean)) |-> ($past(raw) == clean));

  a_r7_steady_when_equal: assert property (@(posedge clk) disable iff (rst)
    (raw == clean) |=> $stable(clean));

endmodule

// File: rtl/gdi_leg.sv
module gdi_leg
  import gdi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hi_f,
  input  logic lo_f,
  input  logic allow,
  output logic ho,
  output logic lo
);
  leg_state_e nxt;

  always_comb begin
    nxt = allow ? resolve_leg(hi_f, lo_f) : LEG_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ho <= 1'b0;
      lo <= 1'b0;
    end else begin
      ho <= (nxt == LEG_HIGH);
      lo <= (nxt == LEG_LOW);
    end
  end

  a_r4_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
    !(ho && lo));

  a_r5_blocked_off: assert property (@(posedge clk) disable iff (rst)
    !allow |=> (!ho && !lo));

  a_r1_high_side: assert property (@(posedge clk) disable iff (rst)
    (allow && hi_f && !lo_f) |=> (ho && !lo));

  a_r2_low_side: assert property (@(posedge clk) disable iff (rst)
    (allow && !hi_f && lo_f) |=> (!ho && lo));

endmodule

// File: rtl/gdi_interlock.sv
module gdi_interlock #(
  parameter int NPH     = 3,
  parameter int FILT_IN = 8,
  parameter int FILT_EN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] hin,
  input  logic [NPH-1:0] lin,
  input  logic           en_in,
  input  logic           fault_in,
  output logic [NPH-1:0] ho,
  output logic [NPH-1:0] lo
);
  localparam int NCH = 2 * NPH;

  logic [NCH-1:0] raw_cmd;
  logic [NCH-1:0] flt_cmd;
  logic           en_f;
  logic           allow;

  assign raw_cmd = {lin, hin};

  for (genvar c = 0; c < NCH; c++) begin : g_cmd_filt
    gdi_deglitch #(.LEN(FILT_IN)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_cmd[c]),
      .clean (flt_cmd[c])
    );
  end

  gdi_deglitch #(.LEN(FILT_EN)) u_en_filt (
    .clk   (clk),
    .rst   (rst),
    .raw   (en_in),
    .clean (en_f)
  );

  assign allow = en_f && !fault_in;

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    gdi_leg u_leg (
      .clk   (clk),
      .rst   (rst),
      .hi_f  (flt_cmd[p]),
      .lo_f  (flt_cmd[NPH + p]),
      .allow (allow),
      .ho    (ho[p]),
      .lo    (lo[p])
    );
  end

  a_r10_fault_kill: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> (ho == '0 && lo == '0));

  a_r11_reset_off: assert property (@(posedge clk)
    rst |=> (ho == '0 && lo == '0));

endmodule

// File: tb/gdi_interlock_tb.sv
module gdi_interlock_tb;
  localparam int NPH     = 3;
  localparam int FILT_IN = 8;
  localparam int FILT_EN = 4;
  localparam int NCH     = 2 * NPH;
  localparam int EN_IDX  = NCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] hin = '0;
  logic [NPH-1:0] lin = '0;
  logic en_in = 1'b0;
  logic fault_in = 1'b0;
  logic [NPH-1:0] ho;
  logic [NPH-1:0] lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gdi_interlock #(.NPH(NPH), .FILT_IN(FILT_IN), .FILT_EN(FILT_EN)) u_dut (
    .clk(clk), .rst(rst), .hin(hin), .lin(lin),
    .en_in(en_in), .fault_in(fault_in), .ho(ho), .lo(lo)
  );

  // Behavioural reference: history queue per input, accepted level per input
  bit hist [NCH+1][$];
  bit acc  [NCH+1];
  bit exp_ho [NPH];
  bit exp_lo [NPH];
  string tag [NPH];

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c <= NCH; c++) begin
        hist[c].delete();
        acc[c] = 0;
      end
      for (int p = 0; p < NPH; p++) begin
        exp_ho[p] = 0; exp_lo[p] = 0; tag[p] = "R11";
      end
    end else begin
      for (int p = 0; p < NPH; p++) begin
        bit h, l;
        h = acc[p]; l = acc[NPH + p];
        exp_ho[p] = 0; exp_lo[p] = 0;
        if (fault_in)          tag[p] = "R6";
        else if (!acc[EN_IDX]) tag[p] = "R5";
        else if (h && l)       tag[p] = "R4";
        else if (h)       begin tag[p] = "R1"; exp_ho[p] = 1; end
        else if (l)       begin tag[p] = "R2"; exp_lo[p] = 1; end
        else                   tag[p] = "R3";
      end
      for (int c = 0; c <= NCH; c++) begin
        bit r;
        bit same;
        int len;
        len = (c == EN_IDX) ? FILT_EN : FILT_IN;
        r = (c == EN_IDX) ? en_in : (c < NPH) ? hin[c] : lin[c - NPH];
        hist[c].push_back(r);
        if (hist[c].size() > len) void'(hist[c].pop_front());
        if (hist[c].size() == len && r != acc[c]) begin
          same = 1;
          foreach (hist[c][i]) if (hist[c][i] != r) same = 0;
          if (same) acc[c] = r;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int p = 0; p < NPH; p++) begin
        checks++;
        if (ho[p] !== exp_ho[p] || lo[p] !== exp_lo[p]) begin
          errors++;
          $display("FAIL %s phase %0d: ho/lo actual %b%b expected %b%b at %0t",
                   tag[p], p, ho[p], lo[p], exp_ho[p], exp_lo[p], $time);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [NPH-1:0] eh, input logic [NPH-1:0] el);
    checks++;
    if (ho !== eh || lo !== el) begin
      errors++;
      $display("FAIL %s: ho=%b lo=%b expected ho=%b lo=%b at %0t", req, ho, lo, eh, el, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    tick(4);
    expect_out("R11", '0, '0);
    hin = '1;
    en_in = 1'b1;
    rst = 1'b0;
    tick(1);
    expect_out("R11", '0, '0);
    hin = '0;
    tick(FILT_EN + FILT_IN + 3);

    // R9: matched latency on every PWM channel
    for (int c = 0; c < NCH; c++) begin
      logic [NPH-1:0] m;
      m = NPH'(1) << (c % NPH);
      if (c < NPH) hin = m; else lin = m;
      tick(FILT_IN);
      expect_out("R9", '0, '0);
      tick(1);
      if (c < NPH) expect_out("R9", m, '0); else expect_out("R9", '0, m);
      hin = '0; lin = '0;
      tick(FILT_IN + 2);
    end

    // R7: short pulses rejected on every PWM channel
    seen = 0;
    hin = '1;
    tick(FILT_IN - 1);
    hin = '0; lin = '1;
    tick(FILT_IN - 1);
    lin = '0;
    for (int i = 0; i < FILT_IN + 3; i++) begin
      tick(1);
      if (ho != '0 || lo != '0) seen = 1;
    end
    checks++;
    if (seen) begin
      errors++;
      $display("FAIL R7: actual output pulse expected none");
    end

    // R4: both commands high
    hin = '1; lin = '1;
    tick(FILT_IN + 2);
    expect_out("R4", '0, '0);

    // R1, R2 mixed pattern
    hin = 3'b101; lin = 3'b010;
    tick(FILT_IN + 2);
    expect_out("R1", 3'b101, 3'b010);

    // R8: short enable drop ignored
    en_in = 1'b0;
    tick(FILT_EN - 1);
    en_in = 1'b1;
    tick(FILT_EN + 2);
    expect_out("R8", 3'b101, 3'b010);

    // R8: held enable drop latency
    en_in = 1'b0;
    tick(FILT_EN);
    expect_out("R8", 3'b101, 3'b010);
    tick(1);
    expect_out("R5", '0, '0);
    en_in = 1'b1;
    tick(FILT_EN + 2);

    // R10: fault acts on next edge
    fault_in = 1'b1;
    tick(1);
    expect_out("R10", '0, '0);
    tick(3);
    expect_out("R6", '0, '0);
    fault_in = 1'b0;
    tick(2);
    expect_out("R6", 3'b101, 3'b010);

    // Random segments with collisions of filter expiry and shutdown
    for (int s = 0; s < 600; s++) begin
      hin = NPH'($urandom);
      lin = NPH'($urandom);
      if (($urandom % 6) == 0) en_in = ~en_in;
      fault_in = (($urandom % 8) == 0);
      tick(1 + ($urandom % (2 * FILT_IN + 2)));
    end

    fault_in = 1'b0;
    en_in = 1'b1;
    tick(FILT_IN + 4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule